// File: doc/BRIEF.md
# Single-Tone Bandpass FIR With Converter Conditioning

This block sits between a sampling converter and a pair of output converters. It detects one tone. Each time the input strobe fires, the block takes a 16-bit converter word and cuts it to a signed sample centred on zero. The sample goes into a circular history of the most recent samples. A sequential multiply-accumulate engine then convolves that history with a fixed symmetric bandpass kernel, one tap per clock. The kernel is tuned so that a tone at one eighth of the sample rate passes.

When the sum is complete, the block scales it and re-offsets it into an unsigned mid-scale 12-bit word for the filtered channel. The untouched input is also reduced to 12 bits for a second, monitor channel. A one-cycle pulse tells the consumer that both words have changed.

The strobe is expected at a low rate, for example a 4 kHz sample clock. If a strobe arrives while a sum is still being formed, the block drops it and raises a flag that stays set until reset.

Top module: `tone_fir_top`

## Requirements
- R1: While reset is low and after it is released, `dac_filt`, `dac_raw`, `done` and `overrun` are 0. Every history slot holds a zero sample.
- R2: An accepted word becomes the sample s = (adc_word >> 8) - 127, a signed value in the range -127 to +128.
- R3: The kernel has 101 taps, and tap k has the weight h(k). Let d = |k - 50|. The magnitude is 4*(51 - d). The weight is positive when d mod 8 is 0, 1, 6 or 7, and negative otherwise. This makes the kernel symmetric about tap 50.
- R4: For each accepted sample, the sum is S = Σ h(k)·x(n-k) over k = 0..100. Here x(n) is the new sample and x(n-k) is the sample accepted k strobes earlier. Samples from before reset count as zero.
- R5: The filter result r is bits 22 down to 7 of S in 32-bit two's complement, read as a signed 16-bit value.
- R6: The filtered word is dac_filt = ((((r·5) >>> 2) >>> 4) + 0x7FF) mod 4096, where >>> is an arithmetic shift.
- R7: The monitor word is dac_raw = bits 15 down to 4 of the accepted input word.
- R8: Take the rising edge that accepts a strobe as edge 0. On edge 102, `dac_filt` and `dac_raw` take their new values and `done` goes high for exactly one cycle. On all other edges both words hold their values.
- R9: A strobe sampled on edges 1 to 102 of a running computation is ignored. It does not change the history and does not restart the engine. It sets `overrun`, which then stays at 1 until reset.
- R10: A strobe sampled on the same edge that completes a result (edge 102) is dropped. The result and its `done` pulse still appear unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_strobe | input | 1 | One-cycle marker that a new converter word is on `adc_word` |
| adc_word | input | 16 | Raw converter word |
| dac_filt | output | 12 | Filtered result in offset-binary form |
| dac_raw | output | 12 | Input word reduced to 12 bits |
| done | output | 1 | One-cycle pulse when both output words are updated |
| overrun | output | 1 | Sticky flag for a strobe that was dropped while busy |

## Verification
The completion of a result and the arrival of a new strobe can fall on the same clock edge. This is the edge where the engine hands its sum to the output formatter. The bench provokes the collision by watching its own model count down. It raises the strobe so that the strobe is sampled on exactly the 102nd edge. The bench then expects the finished words and the `done` pulse to appear unchanged, `overrun` to rise, and the next accepted sample's result to show that the dropped word never entered the history.

// File: rtl/tone_fir_pkg.sv
package tone_fir_pkg;

   // Kernel weight for tap k of an odd-length kernel: triangular envelope
   // with a sign pattern of period eight samples.
   function automatic int tap_coef(input int k, input int taps, input int step);
      int c;
      int d;
      int mag;
      int ph;
      c   = (taps - 1) / 2;
      d   = (k > c) ? (k - c) : (c - k);
      mag = step * (c + 1 - d);
      ph  = d % 8;
      return ((ph < 2) || (ph > 5)) ? mag : -mag;
   endfunction

endpackage

// File: rtl/tone_fir_history.sv
module tone_fir_history #(
   parameter int DEPTH = 101,
   parameter int SW    = 9,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic signed [SW-1:0] wr_data,
   input  logic [AW-1:0]        rd_off,
   output logic signed [SW-1:0] rd_data
);

   logic [AW-1:0]        head;
   logic [AW-1:0]        nxt;
   logic [AW-1:0]        rd_idx;
   logic signed [SW-1:0] slot [DEPTH];

   assign nxt = (head == AW'(DEPTH - 1)) ? '0 : head + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= AW'(DEPTH - 1);
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else if (wr_en) begin
         head      <= nxt;
         slot[nxt] <= wr_data;
      end
   end

   // offset 0 is the newest sample; larger offsets walk back in time
   always_comb begin
      if (head >= rd_off)
         rd_idx = head - rd_off;
      else
         rd_idx = AW'(({1'b0, head} + (AW+1)'(DEPTH)) - {1'b0, rd_off});
   end

   assign rd_data = slot[rd_idx];

endmodule

// File: rtl/tone_fir_mac.sv
module tone_fir_mac #(
   parameter int NTAPS     = 101,
   parameter int SW        = 9,
   parameter int COEF_W    = 16,
   parameter int COEF_STEP = 4,
   parameter int ACC_W     = 32,
   parameter int TW        = $clog2(NTAPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [SW-1:0]    sample,
   output logic [TW-1:0]           tap,
   output logic signed [ACC_W-1:0] acc,
   output logic                    running,
   output logic                    fin
);

   localparam int PW = COEF_W + SW;

   logic signed [COEF_W-1:0] coef;
   logic signed [PW-1:0]     prod;

   assign coef = COEF_W'(tone_fir_pkg::tap_coef(int'(tap), NTAPS, COEF_STEP));
   assign prod = coef * sample;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         fin     <= 1'b0;
         tap     <= '0;
         acc     <= '0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            running <= 1'b1;
            tap     <= '0;
            acc     <= '0;
         end else if (running) begin
            acc <= acc + ACC_W'(prod);
            if (tap == TW'(NTAPS - 1)) begin
               running <= 1'b0;
               fin     <= 1'b1;
            end else begin
               tap <= tap + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tone_fir_format.sv
module tone_fir_format #(
   parameter int ACC_W      = 32,
   parameter int RES_W      = 16,
   parameter int RES_TOP    = 22,
   parameter int GAIN_NUM   = 5,
   parameter int GAIN_SHIFT = 2,
   parameter int OUT_SHIFT  = 4,
   parameter int DAC_W      = 12,
   parameter int DAC_MID    = 2047
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic signed [ACC_W-1:0] acc,
   input  logic [DAC_W-1:0]        raw_in,
   output logic [DAC_W-1:0]        dac_filt,
   output logic [DAC_W-1:0]        dac_raw,
   output logic                    done
);

   localparam int MW     = RES_W + 3;
   localparam int RES_LO = RES_TOP - RES_W + 1;

   logic signed [RES_W-1:0] res;
   logic signed [MW-1:0]    mul;
   logic signed [MW-1:0]    shr;
   logic [DAC_W-1:0]        filt_nxt;
   logic                    unused_acc;

   assign res        = acc[RES_TOP:RES_LO];
   assign unused_acc = ^{acc[ACC_W-1:RES_TOP+1], acc[RES_LO-1:0]};
   assign mul        = MW'(res) * MW'(GAIN_NUM);
   assign shr        = mul >>> (GAIN_SHIFT + OUT_SHIFT);
   assign filt_nxt   = shr[DAC_W-1:0] + DAC_W'(DAC_MID);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_filt <= '0;
         dac_raw  <= '0;
         done     <= 1'b0;
      end else begin
         done <= load;
         if (load) begin
            dac_filt <= filt_nxt;
            dac_raw  <= raw_in;
         end
      end
   end

endmodule

// File: rtl/tone_fir_top.sv
module tone_fir_top #(
   parameter int ADC_W      = 16,
   parameter int IN_SHIFT   = 8,
   parameter int IN_OFFSET  = 127,
   parameter int NTAPS      = 101,
   parameter int COEF_W     = 16,
   parameter int COEF_STEP  = 4,
   parameter int ACC_W      = 32,
   parameter int RES_W      = 16,
   parameter int RES_TOP    = 22,
   parameter int GAIN_NUM   = 5,
   parameter int GAIN_SHIFT = 2,
   parameter int OUT_SHIFT  = 4,
   parameter int DAC_W      = 12,
   parameter int DAC_MID    = 2047
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adc_strobe,
   input  logic [ADC_W-1:0] adc_word,
   output logic [DAC_W-1:0] dac_filt,
   output logic [DAC_W-1:0] dac_raw,
   output logic             done,
   output logic             overrun
);

   localparam int SW = ADC_W - IN_SHIFT + 1;
   localparam int TW = $clog2(NTAPS);

   // elaboration-time parameter checks
   if (NTAPS % 2 != 1) begin : g_bad_taps
      $error("tone_fir_top: NTAPS must be odd for a centred symmetric kernel");
   end
   if (RES_TOP >= ACC_W || RES_TOP < RES_W - 1) begin : g_bad_res
      $error("tone_fir_top: result slice lies outside the accumulator");
   end
   if (DAC_W > ADC_W || IN_SHIFT >= ADC_W) begin : g_bad_width
      $error("tone_fir_top: converter widths are inconsistent");
   end

   logic signed [SW-1:0]    samp_in;
   logic signed [SW-1:0]    samp_rd;
   logic [TW-1:0]           tap;
   logic signed [ACC_W-1:0] acc;
   logic                    running;
   logic                    fin;
   logic                    busy;
   logic                    accept;
   logic [DAC_W-1:0]        held_raw;
   logic                    unused_low;

   assign busy       = running | fin;
   assign accept     = adc_strobe & ~busy;
   assign samp_in    = $signed({1'b0, adc_word[ADC_W-1:IN_SHIFT]}) - SW'(IN_OFFSET);
   assign unused_low = ^adc_word[ADC_W-DAC_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_raw <= '0;
         overrun  <= 1'b0;
      end else begin
         if (accept) held_raw <= adc_word[ADC_W-1 -: DAC_W];
         if (adc_strobe && busy) overrun <= 1'b1;
      end
   end

   tone_fir_history #(.DEPTH(NTAPS), .SW(SW), .AW(TW)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept),
      .wr_data (samp_in),
      .rd_off  (tap),
      .rd_data (samp_rd)
   );

   tone_fir_mac #(
      .NTAPS(NTAPS), .SW(SW), .COEF_W(COEF_W), .COEF_STEP(COEF_STEP),
      .ACC_W(ACC_W), .TW(TW)
   ) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .sample  (samp_rd),
      .tap     (tap),
      .acc     (acc),
      .running (running),
      .fin     (fin)
   );

   tone_fir_format #(
      .ACC_W(ACC_W), .RES_W(RES_W), .RES_TOP(RES_TOP), .GAIN_NUM(GAIN_NUM),
      .GAIN_SHIFT(GAIN_SHIFT), .OUT_SHIFT(OUT_SHIFT), .DAC_W(DAC_W), .DAC_MID(DAC_MID)
   ) u_fmt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fin),
      .acc      (acc),
      .raw_in   (held_raw),
      .dac_filt (dac_filt),
      .dac_raw  (dac_raw),
      .done     (done)
   );

endmodule

// File: rtl/tone_fir_chk.sv
module tone_fir_chk #(
   parameter int DAC_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adc_strobe,
   input logic             busy,
   input logic             done,
   input logic             overrun,
   input logic [DAC_W-1:0] dac_filt,
   input logic [DAC_W-1:0] dac_raw
);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(dac_filt));

   // R8
   raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(dac_raw));

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R9
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R9
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(adc_strobe && busy));

   // R8
   accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_strobe && !busy) |=> busy);

endmodule

bind tone_fir_top tone_fir_chk #(.DAC_W(DAC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .adc_strobe (adc_strobe),
   .busy       (busy),
   .done       (done),
   .overrun    (overrun),
   .dac_filt   (dac_filt),
   .dac_raw    (dac_raw)
);

// File: tb/tb_tone_fir_top.sv
`timescale 1ns/1ps
module tb_tone_fir_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adc_strobe = 1'b0;
   logic [15:0] adc_word = 16'h0;
   logic [11:0] dac_filt;
   logic [11:0] dac_raw;
   logic        done;
   logic        overrun;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   tone_fir_top dut (
      .clk(clk), .rst_n(rst_n), .adc_strobe(adc_strobe), .adc_word(adc_word),
      .dac_filt(dac_filt), .dac_raw(dac_raw), .done(done), .overrun(overrun)
   );

   // ---------------- reference model ----------------
   int rem = 0;
   int m_done = 0;
   int m_ovr = 0;
   int m_filt = 0;
   int m_raw = 0;
   int p_filt = 0;
   int p_raw = 0;
   int hist[$];
   bit was_busy;

   function automatic int ref_coef(int k);
      int d;
      int ph;
      d  = (k > 50) ? k - 50 : 50 - k;
      ph = d % 8;
      return ((ph < 2) || (ph > 5)) ? 4 * (51 - d) : -4 * (51 - d);
   endfunction

   task automatic model_accept(input int word);
      int s;
      int sum;
      int r;
      int sc;
      s = (word >> 8) - 127;
      hist.push_front(s);
      void'(hist.pop_back());
      sum = 0;
      for (int k = 0; k < 101; k++) sum += hist[k] * ref_coef(k);
      r = (sum >>> 7) & 16'hFFFF;
      if (r > 32767) r -= 65536;
      sc = (r * 5) >>> 2;
      sc = sc >>> 4;
      p_filt = (sc + 2047) & 12'hFFF;
      p_raw  = (word >> 4) & 12'hFFF;
      rem = 102;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         rem = 0; m_done = 0; m_ovr = 0; m_filt = 0; m_raw = 0;
         hist.delete();
         for (int i = 0; i < 101; i++) hist.push_back(0);
      end else begin
         was_busy = (rem != 0);
         m_done = 0;
         if (rem == 1) begin
            m_done = 1; m_filt = p_filt; m_raw = p_raw;
         end
         if (rem != 0) rem--;
         if (adc_strobe) begin
            if (was_busy) m_ovr = 1;
            else model_accept(int'(adc_word));
         end
      end
   end

   // ---------------- checking ----------------
   task automatic check(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   bit compare_on = 1'b0;
   always @(negedge clk) begin
      if (compare_on && rst_n) begin
         check("R8 done pulse", int'(done), m_done);
         check("R9 overrun flag", int'(overrun), m_ovr);
         check("R7 raw word", int'(dac_raw), m_raw);
         check("R2 R3 R4 R5 R6 filtered word", int'(dac_filt), m_filt);
      end
   end

   task automatic send(input logic [15:0] w);
      @(negedge clk);
      adc_strobe = 1'b1; adc_word = w;
      @(negedge clk);
      adc_strobe = 1'b0; adc_word = 16'h1234;
      while (rem != 0) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int tone[8] = '{0, 90, 127, 90, 0, -90, -127, -90};
      repeat (4) @(negedge clk);
      // R1 reset values while held in reset
      check("R1 dac_filt in reset", int'(dac_filt), 0);
      check("R1 dac_raw in reset", int'(dac_raw), 0);
      check("R1 done in reset", int'(done), 0);
      check("R1 overrun in reset", int'(overrun), 0);
      rst_n = 1'b1;
      compare_on = 1'b1;
      @(negedge clk);
      check("R1 outputs after release", int'(dac_filt) + int'(dac_raw), 0);

      // impulse of +1 then zeros: the zero history from reset shows (R1 R4)
      send(16'h8000);
      check("R6 impulse word", int'(dac_filt), 2046);
      for (int i = 0; i < 6; i++) send(16'h7F00);
      // extremes of the conditioned range (R2)
      send(16'hFFFF);
      send(16'h0000);
      send(16'hFF0F);
      check("R7 raw of last word", int'(dac_raw), 12'hFF0);
      // in-band tone, long enough to wrap the history (R4)
      for (int i = 0; i < 120; i++) send(16'((tone[i % 8] + 127) << 8 | 16'h005A));

      // R9: strobe in mid computation is ignored and flags overrun
      @(negedge clk);
      adc_strobe = 1'b1; adc_word = 16'h7F00;
      @(negedge clk);
      adc_strobe = 1'b0;
      repeat (30) @(negedge clk);
      adc_strobe = 1'b1; adc_word = 16'hFFFF;
      @(negedge clk);
      adc_strobe = 1'b0;
      check("R9 overrun set", int'(overrun), 1);
      while (rem != 0) @(negedge clk);
      send(16'h7F00);
      check("R9 overrun sticky", int'(overrun), 1);

      // R10: strobe lands on the completing edge
      @(negedge clk);
      adc_strobe = 1'b1; adc_word = 16'hC000;
      @(negedge clk);
      adc_strobe = 1'b0;
      while (rem != 1) @(negedge clk);
      adc_strobe = 1'b1; adc_word = 16'h0100;
      @(negedge clk);
      adc_strobe = 1'b0;
      check("R10 done on colliding edge", int'(done), 1);
      check("R10 raw word of completed sample", int'(dac_raw), 12'hC00);
      @(negedge clk);
      check("R10 engine stays idle", int'(done), 0);
      send(16'h7F00);
      send(16'h8000);

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule